// File: doc/BRIEF.md
# Instruction Decode and Timing Generator

This block is the front end of a hardwired control unit. It works on 16-bit instruction words. When the load strobe is asserted, it stores an instruction. The top bit goes into a separate indirect flip-flop. The next three bits form the operation code, and the block decodes them into eight one-hot operation lines. The low twelve bits go straight out as the address field.

Alongside this, a 4-bit sequence counter steps through the phases of an instruction. Its value is decoded into sixteen one-hot timing lines. Control gates further down combine these with the operation lines to produce the micro-operations.

The surrounding control logic has two counter controls. It raises the step input to move to the next phase. It raises the clear input to go back to phase zero, usually at the end of an instruction. Every change happens on the rising clock edge, so each output is one register stage after the input that caused it.

Top module: `hw_timing_front`

## Requirements
- R1: While reset is asserted (rstN low) and after reset, until the first load or counter step: timeLines is 16'h0001 (timing line 0 active), opLines is 8'h01 (operation line 0 active), indirectBit is 0 and addrField is 0.
- R2: When loadInstr is high at a rising edge, after that edge indirectBit equals bit 15 of instrIn, and opLines has exactly bit n set, where n is the value of instrIn bits 14..12.
- R3: When loadInstr is high at a rising edge, after that edge addrField equals instrIn bits 11..0.
- R4: When loadInstr is low at a rising edge, opLines, indirectBit and addrField keep their values, whatever instrIn carries.
- R5: When seqInc is high and seqClr is low at a rising edge, the active timing line moves from line k to line k+1.
- R6: Stepping from timing line 15 wraps around to timing line 0.
- R7: When seqClr is high at a rising edge, timing line 0 is active after that edge.
- R8: Clear takes priority over increment: with seqClr and seqInc both high, the counter goes to 0 and does not advance.
- R9: With seqInc and seqClr both low, the active timing line does not change.
- R10: In every cycle out of reset, exactly one of the timing lines and exactly one of the operation lines is high.
- R11: Loading an instruction and stepping or clearing the counter in the same cycle both take effect on that edge, each independent of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadInstr | input | 1 | Captures instrIn into the instruction register |
| instrIn | input | 16 | Instruction word |
| seqInc | input | 1 | Advances the sequence counter by one |
| seqClr | input | 1 | Returns the sequence counter to zero |
| opLines | output | 8 | One-hot decoded operation code |
| indirectBit | output | 1 | Indirect flip-flop, from instruction bit 15 |
| addrField | output | 12 | Address field of the held instruction |
| timeLines | output | 16 | One-hot timing signals decoded from the counter |

## Verification
Two events can fall in the same cycle: a clear and an increment of the sequence counter. The bench provokes this from several counter positions, including position 15, where a missed priority would look like a wrap. It also provokes it while an instruction load is pending. After each edge, the reference model's counter is compared against the active timing line, so an increment that wins over the clear shows up as line 1 or as the next line instead of line 0.

// File: rtl/hwt_pkg.sv
package hwt_pkg;

  // Strobes resolved by the control module and consumed by the datapath.
  typedef struct packed {
    logic irLoad;   // capture the instruction word
    logic cntStep;  // advance the sequence counter
    logic cntZero;  // return the sequence counter to zero
  } hwt_strobe_t;

endpackage

// File: rtl/hwt_onehot_dec.sv
module hwt_onehot_dec #(
  parameter int SEL_W = 3,
  localparam int N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [N-1:0]     lines
);

  for (genvar i = 0; i < N; i++) begin : g_line
    assign lines[i] = (sel == SEL_W'(i));
  end

endmodule

// File: rtl/hwt_seq_ctrl.sv
module hwt_seq_ctrl
  import hwt_pkg::*;
(
  input  logic        loadInstr,
  input  logic        seqInc,
  input  logic        seqClr,
  output hwt_strobe_t strobes
);

  // Clear wins over increment; a load is independent of both.
  always_comb begin
    strobes         = '0;
    strobes.irLoad  = loadInstr;
    strobes.cntZero = seqClr;
    strobes.cntStep = seqInc && !seqClr;
  end

endmodule

// File: rtl/hwt_datapath.sv
module hwt_datapath
  import hwt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OP_W   = 3,
  parameter int CNT_W  = 4,
  localparam int ADDR_W = WORD_W - OP_W - 1,
  localparam int NUM_OP = 1 << OP_W,
  localparam int NUM_T  = 1 << CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  hwt_strobe_t       strobes,
  input  logic [WORD_W-1:0] instrIn,
  output logic [NUM_OP-1:0] opLines,
  output logic              indirectBit,
  output logic [ADDR_W-1:0] addrField,
  output logic [NUM_T-1:0]  timeLines
);

  localparam int IND_POS = WORD_W - 1;
  localparam int BODY_W  = WORD_W - 1;

  logic [BODY_W-1:0] irBody;
  logic              indFlop;
  logic [CNT_W-1:0]  seqCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irBody  <= '0;
      indFlop <= 1'b0;
    end else if (strobes.irLoad) begin
      irBody  <= instrIn[BODY_W-1:0];
      indFlop <= instrIn[IND_POS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqCount <= '0;
    end else if (strobes.cntZero) begin
      seqCount <= '0;
    end else if (strobes.cntStep) begin
      seqCount <= seqCount + CNT_W'(1);
    end
  end

  hwt_onehot_dec #(.SEL_W(OP_W)) u_opDec (
    .sel   (irBody[BODY_W-1:ADDR_W]),
    .lines (opLines)
  );

  hwt_onehot_dec #(.SEL_W(CNT_W)) u_timeDec (
    .sel   (seqCount),
    .lines (timeLines)
  );

  assign indirectBit = indFlop;
  assign addrField   = irBody[ADDR_W-1:0];

endmodule

// File: rtl/hw_timing_front.sv
module hw_timing_front
  import hwt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OP_W   = 3,
  parameter int CNT_W  = 4,
  localparam int ADDR_W = WORD_W - OP_W - 1,
  localparam int NUM_OP = 1 << OP_W,
  localparam int NUM_T  = 1 << CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadInstr,
  input  logic [WORD_W-1:0] instrIn,
  input  logic              seqInc,
  input  logic              seqClr,
  output logic [NUM_OP-1:0] opLines,
  output logic              indirectBit,
  output logic [ADDR_W-1:0] addrField,
  output logic [NUM_T-1:0]  timeLines
);

  hwt_strobe_t strobes;

  hwt_seq_ctrl u_ctrl (
    .loadInstr (loadInstr),
    .seqInc    (seqInc),
    .seqClr    (seqClr),
    .strobes   (strobes)
  );

  hwt_datapath #(
    .WORD_W (WORD_W),
    .OP_W   (OP_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .instrIn     (instrIn),
    .opLines     (opLines),
    .indirectBit (indirectBit),
    .addrField   (addrField),
    .timeLines   (timeLines)
  );

endmodule

// File: rtl/hw_timing_front_chk.sv
module hw_timing_front_chk #(
  parameter int WORD_W = 16,
  parameter int OP_W   = 3,
  parameter int CNT_W  = 4,
  localparam int ADDR_W = WORD_W - OP_W - 1,
  localparam int NUM_OP = 1 << OP_W,
  localparam int NUM_T  = 1 << CNT_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadInstr,
  input logic [WORD_W-1:0] instrIn,
  input logic              seqInc,
  input logic              seqClr,
  input logic [NUM_OP-1:0] opLines,
  input logic              indirectBit,
  input logic [ADDR_W-1:0] addrField,
  input logic [NUM_T-1:0]  timeLines
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  logic [NUM_T-1:0] rotT;
  assign rotT = {timeLines[NUM_T-2:0], timeLines[NUM_T-1]};

  logic [NUM_OP-1:0] opFromWord;
  assign opFromWord = NUM_OP'(1) << instrIn[WORD_W-2 -: OP_W];

  // R10
  p_one_time_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(timeLines) == 1);
  p_one_op_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(opLines) == 1);
  // R2
  p_load_op_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && loadInstr) |=> (opLines == $past(opFromWord)
                              && indirectBit == $past(instrIn[WORD_W-1])));
  // R3
  p_load_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && loadInstr) |=> addrField == $past(instrIn[ADDR_W-1:0]));
  // R4
  p_hold_ir_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !loadInstr) |=> ($stable(opLines) && $stable(indirectBit)
                               && $stable(addrField)));
  // R5, R6
  p_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && seqInc && !seqClr) |=> timeLines == $past(rotT));
  // R7, R8
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && seqClr) |=> timeLines[0]);
  // R9
  p_hold_t_r9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !seqInc && !seqClr) |=> $stable(timeLines));

endmodule

bind hw_timing_front hw_timing_front_chk #(
  .WORD_W (WORD_W),
  .OP_W   (OP_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .loadInstr   (loadInstr),
  .instrIn     (instrIn),
  .seqInc      (seqInc),
  .seqClr      (seqClr),
  .opLines     (opLines),
  .indirectBit (indirectBit),
  .addrField   (addrField),
  .timeLines   (timeLines)
);

// File: tb/test_hw_timing_front.sv
`timescale 1ns/1ps
module test_hw_timing_front;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadInstr = 1'b0;
  logic [15:0] instrIn = '0;
  logic        seqInc = 1'b0;
  logic        seqClr = 1'b0;
  logic [7:0]  opLines;
  logic        indirectBit;
  logic [11:0] addrField;
  logic [15:0] timeLines;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  int refCount = 0;
  int refWord  = 0;

  always #2.5 clk = ~clk;

  hw_timing_front i_hw_timing_front (
    .clk         (clk),
    .rstN        (rstN),
    .loadInstr   (loadInstr),
    .instrIn     (instrIn),
    .seqInc      (seqInc),
    .seqClr      (seqClr),
    .opLines     (opLines),
    .indirectBit (indirectBit),
    .addrField   (addrField),
    .timeLines   (timeLines)
  );

  task automatic checkVal(string tag, string what, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, actual, expected);
    end
  endtask

  task automatic compareAll(string tag);
    int ones;
    checkVal(tag, "timeLines", int'(timeLines), 1 << refCount);
    checkVal(tag, "opLines", int'(opLines), 1 << ((refWord >> 12) & 7));
    checkVal(tag, "indirectBit", int'(indirectBit), (refWord >> 15) & 1);
    checkVal(tag, "addrField", int'(addrField), refWord & 12'hfff);
    ones = $countones(timeLines) * 16 + $countones(opLines);
    checkVal("R10", "one-hot counts", ones, 17);
  endtask

  // Apply one cycle of stimulus (called just after a falling edge),
  // advance the model at the rising edge, compare at the next falling edge.
  task automatic step(bit ld, logic [15:0] word, bit inc, bit clr, string tag);
    loadInstr = ld;
    instrIn   = word;
    seqInc    = inc;
    seqClr    = clr;
    @(posedge clk);
    if (clr)      refCount = 0;
    else if (inc) refCount = (refCount + 1) % 16;
    if (ld)       refWord = int'(word);
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1");          // during reset
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");          // after reset, idle inputs

    // R2, R3: load every operation code with varied indirect and address bits
    for (int op = 0; op < 8; op++) begin
      step(1'b1, {op[0], op[2:0], 12'(op * 12'h1a5 + 3)}, 1'b0, 1'b0, "R2");
    end
    step(1'b1, 16'hb5a3, 1'b0, 1'b0, "R3");

    // R4: loads off, word bus changing
    step(1'b0, 16'h7fff, 1'b0, 1'b0, "R4");
    step(1'b0, 16'h0000, 1'b0, 1'b0, "R4");

    // R5 and R6: walk every line and wrap
    for (int k = 0; k < 17; k++) step(1'b0, 16'h1234, 1'b1, 1'b0, "R5");
    step(1'b0, '0, 1'b0, 1'b0, "R9");
    step(1'b0, '0, 1'b0, 1'b0, "R9");

    // R6: reach line 15 and step once more
    for (int k = 0; k < 14; k++) step(1'b0, '0, 1'b1, 1'b0, "R5");
    step(1'b0, '0, 1'b1, 1'b0, "R6");

    // R7: clear from mid position
    for (int k = 0; k < 6; k++) step(1'b0, '0, 1'b1, 1'b0, "R5");
    step(1'b0, '0, 1'b0, 1'b1, "R7");

    // R8: clear with increment from several positions, including 15
    for (int pos = 0; pos < 16; pos += 5) begin
      for (int k = 0; k < pos; k++) step(1'b0, '0, 1'b1, 1'b0, "R5");
      step(1'b0, '0, 1'b1, 1'b1, "R8");
    end
    for (int k = 0; k < 15; k++) step(1'b0, '0, 1'b1, 1'b0, "R5");
    step(1'b0, '0, 1'b1, 1'b1, "R8");

    // R11: load together with step, and together with clear plus step
    step(1'b1, 16'h6abc, 1'b1, 1'b0, "R11");
    step(1'b1, 16'hf001, 1'b1, 1'b0, "R11");
    step(1'b1, 16'h2fff, 1'b1, 1'b1, "R11");

    // Mixed patterns
    for (int n = 0; n < 200; n++) begin
      logic [15:0] w;
      logic [2:0]  c;
      w = 16'($urandom);
      c = 3'($urandom);
      step(c[0], w, c[1], c[2] & c[1] & c[0], "R11");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule